// File: doc/BRIEF.md
# Single-Channel TDM PCM Port

This block connects one voice channel to a serial time-division PCM bus. The bus bit clock runs nominally at 2.048 MHz. An active-low sync line is sampled on every rising clock edge. When the port sees a fresh low level, it opens an 8-bit channel slot. In that slot it shifts one PCM word out on a three-state serial output. At the same time it collects one PCM word from the serial input and one 8-bit control word from a separate serial control line.

On the codec side the port offers a parallel transmit word, which is captured when a slot opens. It also offers the assembled receive word and control word, which are qualified by a one-cycle valid strobe. Outside the slot the serial output is released to high impedance, so other channels can share the bus.

The slot sequencer has two states. IDLE waits for a sync start. A sync start is the sync line sampled low on an edge after it was sampled high on the previous edge. The transitions are:
- IDLE to SLOT on a sync start.
- SLOT to SLOT while the bit counter advances.
- SLOT to SLOT with the counter cleared, when a sync start arrives on the edge that ends the last bit (back-to-back slots).
- SLOT to IDLE after the last bit when no sync start is present.

Top module: `pcm_chan_port`

## Requirements
- R1: While reset is asserted, `pcm_oe` and `rx_valid` are 0, and `rx_word` and `ctl_word` are 0.
- R2: A rising edge that samples `sync_n` low, where the previous sampled value was high, opens a slot. This includes the first edge after reset, for which the previous value counts as high. `pcm_oe` is 1 from that edge for exactly 8 clock cycles.
- R3: `tx_word` is captured on the edge that opens the slot. Its bits leave on `pcm_out`, bit 7 first, each launched on a rising edge. Changes to `tx_word` during the slot have no effect.
- R4: Outside the slot, `pcm_oe` is 0 and `pcm_out` is released to high impedance. Inside the slot, `pcm_out` carries the current transmit bit.
- R5: `pcm_in` is sampled on the falling edge in the middle of each slot bit. The first bit received is bit 7 of `rx_word`. After the falling edge of the eighth bit, `rx_word` holds the new word and `rx_valid` is high for one clock cycle.
- R6: `ctl_in` is sampled on the same falling edges as `pcm_in`, with the first bit as bit 7. `ctl_word` is updated together with `rx_word`. Activity on `ctl_in` outside a slot leaves `ctl_word` unchanged.
- R7: Inside an open slot, `sync_n` held low or pulsed low again neither restarts nor extends the slot.
- R8: A sync start on the edge that ends the eighth bit opens a new slot straight away. `pcm_oe` stays high and the new `tx_word` is captured.
- R9: Activity on `pcm_in` outside a slot leaves `rx_word` unchanged and raises no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame and channel sync |
| pcm_in | input | 1 | Serial PCM receive data |
| ctl_in | input | 1 | Serial control data |
| tx_word | input | WORD_W | Parallel word to transmit |
| pcm_out | output | 1 | Three-state serial PCM transmit data |
| pcm_oe | output | 1 | High while `pcm_out` is driven |
| rx_word | output | WORD_W | Last received PCM word |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_word` and `ctl_word` |
| ctl_word | output | WORD_W | Last received control word |

## Verification
The bench goes after four corner cases:
- **Sync held low through a whole slot, or pulsed again mid-slot.** A design that treats a low level as a start would stretch the slot or restart its bit count, and the output enable would stay high too long.
- **A sync start exactly on the closing edge.** A design that passes through IDLE first would drop the enable for one cycle and lose the first bit of the second word.
- **The transmit word changing during a slot.** A design that does not capture the word on the opening edge would show the mid-slot change in the serial bits.
- **Serial data and control activity between slots.** A design that shifts outside the window would corrupt the held receive and control words or raise a stray valid strobe.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } slot_state_e;
endpackage

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic slot_on,
    output logic last_bit,
    output logic load_word,
    output logic shift_word
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sync_prev_q;
    logic             sync_start;

    assign sync_start = !sync_n && sync_prev_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_start) begin
                    state_d = ST_SLOT;
                    cnt_d   = '0;
                end
            end
            ST_SLOT: begin
                if (cnt_q != LAST) begin
                    cnt_d = cnt_q + 1'b1;
                end else if (sync_start) begin
                    cnt_d = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            sync_prev_q <= 1'b1;
        end else begin
            state_q     <= state_d;
            cnt_q       <= cnt_d;
            sync_prev_q <= sync_n;
        end
    end

    // outputs
    always_comb begin
        slot_on    = 1'b0;
        last_bit   = 1'b0;
        load_word  = 1'b0;
        shift_word = 1'b0;
        unique case (state_q)
            ST_IDLE: load_word = sync_start;
            ST_SLOT: begin
                slot_on    = 1'b1;
                last_bit   = (cnt_q == LAST);
                load_word  = sync_start && (cnt_q == LAST);
                shift_word = (cnt_q != LAST);
            end
            default: ;
        endcase
    end

    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_on && !sync_n && sync_prev_q) |=> (slot_on && cnt_q == '0));

    p_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !(!sync_n && sync_prev_q)) |=> !slot_on);

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_on && cnt_q != LAST) |=> (slot_on && cnt_q == $past(cnt_q) + 1'b1));

    p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !sync_n && sync_prev_q) |=> (slot_on && cnt_q == '0));
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_word,
    input  logic              shift_word,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out
);
    logic [WORD_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load_word) begin
            shreg_q <= par_in;
        end else if (shift_word) begin
            shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
        end
    end

    assign ser_out = shreg_q[WORD_W-1];

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_word |=> (shreg_q == $past(par_in)));

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_word && !load_word) |=> (ser_out == $past(shreg_q[WORD_W-2])));
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
    parameter int WORD_W = 8,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          slot_on,
    input  logic                          last_bit,
    input  logic [LANES-1:0]              din,
    output logic [LANES-1:0][WORD_W-1:0]  words,
    output logic                          valid
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [WORD_W-1:0] sh_q;
        logic [WORD_W-1:0] word_q;

        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q   <= '0;
                word_q <= '0;
            end else if (slot_on) begin
                sh_q <= {sh_q[WORD_W-2:0], din[g]};
                if (last_bit) begin
                    word_q <= {sh_q[WORD_W-2:0], din[g]};
                end
            end
        end

        assign words[g] = word_q;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else begin
            valid <= slot_on && last_bit;
        end
    end

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6 and R9: held words only move together with the valid strobe
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(words));
endmodule

// File: rtl/pcm_chan_port.sv
module pcm_chan_port #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              pcm_in,
    input  logic              ctl_in,
    input  logic [WORD_W-1:0] tx_word,
    output logic              pcm_out,
    output logic              pcm_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic [WORD_W-1:0] ctl_word
);
    localparam int LANES = 2;

    logic                         slot_on;
    logic                         last_bit;
    logic                         load_word;
    logic                         shift_word;
    logic                         tx_bit;
    logic [LANES-1:0][WORD_W-1:0] lane_words;

    pcm_slot_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n     (sync_n),
        .slot_on    (slot_on),
        .last_bit   (last_bit),
        .load_word  (load_word),
        .shift_word (shift_word)
    );

    pcm_tx_serializer #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_word  (load_word),
        .shift_word (shift_word),
        .par_in     (tx_word),
        .ser_out    (tx_bit)
    );

    pcm_rx_deserializer #(.WORD_W(WORD_W), .LANES(LANES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_on  (slot_on),
        .last_bit (last_bit),
        .din      ({ctl_in, pcm_in}),
        .words    (lane_words),
        .valid    (rx_valid)
    );

    assign pcm_oe   = slot_on;
    assign pcm_out  = slot_on ? tx_bit : 1'bz;
    assign rx_word  = lane_words[0];
    assign ctl_word = lane_words[1];

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!pcm_oe && !rx_valid));
endmodule

// File: tb/sim_pcm_chan_port.sv
module sim_pcm_chan_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b1;
    logic       pcm_in = 1'b0;
    logic       ctl_in = 1'b0;
    logic [7:0] tx_word = 8'h00;
    wire        pcm_out;
    logic       pcm_oe;
    logic [7:0] rx_word;
    logic       rx_valid;
    logic [7:0] ctl_word;

    always #5 clk = ~clk;

    pcm_chan_port #(.WORD_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pcm_in(pcm_in),
        .ctl_in(ctl_in), .tx_word(tx_word), .pcm_out(pcm_out),
        .pcm_oe(pcm_oe), .rx_word(rx_word), .rx_valid(rx_valid),
        .ctl_word(ctl_word)
    );

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // behavioural reference
    bit       m_prev = 1;
    bit       m_act  = 0;
    int       m_cnt  = 0;
    bit [7:0] m_txw  = 0;
    bit [7:0] m_rxw  = 0;
    bit [7:0] m_ctw  = 0;
    bit       m_valid = 0;
    bit       rq[$];
    bit       cq[$];

    function automatic bit [7:0] pack(input bit q[$]);
        bit [7:0] w = 0;
        foreach (q[i]) w = {w[6:0], q[i]};
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic s, input logic r, input logic c,
                        input logic [7:0] w, input string req);
        bit start;
        sync_n = s; pcm_in = r; ctl_in = c; tx_word = w;
        if (m_act) begin rq.push_back(r); cq.push_back(c); end
        m_valid = m_act && (m_cnt == 7);
        if (m_valid) begin
            m_rxw = pack(rq); m_ctw = pack(cq);
            rq.delete(); cq.delete();
        end
        @(posedge clk); #2;
        start  = !s && m_prev;
        m_prev = s;
        if (m_act && m_cnt < 7) m_cnt++;
        else if (start) begin m_act = 1; m_cnt = 0; m_txw = w; end
        else m_act = 0;
        chk(pcm_oe === m_act, {req, " R2 R4"}, "pcm_oe", int'(pcm_oe), int'(m_act));
        if (m_act)
            chk(pcm_out === m_txw[7-m_cnt], {req, " R3"}, "pcm_out",
                int'(pcm_out), int'(m_txw[7-m_cnt]));
        chk(rx_valid === m_valid, {req, " R5"}, "rx_valid", int'(rx_valid), int'(m_valid));
        chk(rx_word === m_rxw, {req, " R5 R9"}, "rx_word", int'(rx_word), int'(m_rxw));
        chk(ctl_word === m_ctw, {req, " R6"}, "ctl_word", int'(ctl_word), int'(m_ctw));
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b1, i[0], ~i[1], 8'hEE, req);
    endtask

    // mode: 0 plain, 1 sync held low, 2 sync re-pulsed mid slot, 3 tx_word changes
    task automatic slot(input logic [7:0] txw, input logic [7:0] rxw, input logic [7:0] ctw,
                        input bit lead, input int mode, input bit b2b,
                        input logic [7:0] nxt, input string req);
        if (lead) step(1'b0, ~rxw[0], 1'b1, txw, req);
        for (int i = 0; i < 8; i++) begin
            logic s;
            logic [7:0] w;
            s = 1'b1;
            if (mode == 1) s = 1'b0;
            if (mode == 2 && i == 2) s = 1'b0;
            if (b2b && i == 7) s = 1'b0;
            w = (mode == 3) ? ~txw : txw;
            if (i == 7) w = nxt;
            step(s, rxw[7-i], ctw[7-i], w, req);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(pcm_oe === 1'b0, "R1", "pcm_oe", int'(pcm_oe), 0);
        chk(rx_valid === 1'b0, "R1", "rx_valid", int'(rx_valid), 0);
        chk(rx_word === 8'h00, "R1", "rx_word", int'(rx_word), 0);
        chk(ctl_word === 8'h00, "R1", "ctl_word", int'(ctl_word), 0);
        rst_n = 1'b1;

        idle(5, "R9 R6 idle");
        slot(8'hA5, 8'h3C, 8'h96, 1, 0, 0, 8'h11, "R2 basic");
        idle(3, "R9 after");
        slot(8'hFF, 8'h00, 8'hFF, 1, 0, 0, 8'h22, "R3 ones");
        slot(8'h00, 8'hFF, 8'h00, 1, 0, 0, 8'h33, "R5 zeros");
        idle(4, "R6 idle ctl");
        slot(8'h5A, 8'hC3, 8'h81, 1, 3, 0, 8'h44, "R3 word change");
        idle(2, "R4 gap");
        slot(8'h69, 8'h17, 8'h42, 1, 2, 0, 8'h55, "R7 repulse");
        idle(2, "R7 gap");
        slot(8'hC6, 8'hB4, 8'h2D, 1, 1, 0, 8'h66, "R7 held low");
        step(1'b0, 1'b1, 1'b1, 8'h77, "R7 still low");
        idle(3, "R7 release");
        slot(8'h81, 8'h7E, 8'h55, 1, 0, 1, 8'h18, "R8 first");
        slot(8'h18, 8'hE7, 8'hAA, 0, 0, 0, 8'h99, "R8 second");
        idle(6, "R9 tail");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule